// File: doc/BRIEF.md
# Data Address Watchpoint Qualifier

This unit watches the data side of a load/store pipeline for accesses to one programmed doubleword. Software loads a watch address and a control word through a special-register write port. Each access arrives with its effective address, its direction (load or store) and three machine-state bits: problem state, hypervisor state and data relocation. The unit decides whether the access counts as a watchpoint hit.

An access hits only when several conditions hold together. Its address must fall in the watched doubleword. Its direction must be enabled. The current privilege mode must be enabled. Its relocation state must agree with the selected translation setting, unless that setting is ignored. On a hit the unit raises a one-cycle data-storage interrupt request. With the request it presents the access address for the fault-address register and a status word in which only the watchpoint cause bit is set.

All bit numbers below use big-endian numbering within a 64-bit word: bit 0 is the most significant bit and bit 63 the least significant.

Top module: `dwatch_unit`

## Requirements
- R1: After reset, `irq_dsi`, `fault_addr` and `fault_status` are zero. Both registers are zero, so no access hits until software programs them.
- R2: A write with `spr_we`=1 loads the watch address when `spr_sel`=0 and the control word when `spr_sel`=1. The new value applies to accesses from the next cycle on.
- R3: The address check passes when the access address and the watch address agree in every bit above the 3-bit doubleword offset. The offset bits are ignored.
- R4: Control bit 57 enables loads (`acc_is_store`=0). Control bit 58 enables stores (`acc_is_store`=1). An access whose direction is not enabled never hits.
- R5: When `msr_pr`=1 and control bit 63 (problem-state enable) is clear, the access does not hit.
- R6: Otherwise, when `msr_hv`=1 and control bit 61 (hypervisor enable) is clear, the access does not hit.
- R7: Otherwise, when control bit 62 (supervisor enable) is clear, the access does not hit. This bit must be set for any hit.
- R8: When control bit 60 (translation-ignore) is clear, a hit also requires `msr_dr` to equal control bit 59 (translation-match).
- R9: When control bit 60 is set, `msr_dr` has no effect on the hit decision.
- R10: In the cycle after a qualified hit, `irq_dsi`=1, `fault_addr` equals the access address and `fault_status` has only bit 41 set (value 0x0000_0000_0040_0000).
- R11: The outputs are registered per access. An access cycle without a hit, or a cycle with `acc_valid`=0, gives `irq_dsi`=0 and zero `fault_addr` and `fault_status` in the next cycle. Each hitting access therefore raises exactly one single-cycle request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spr_we | input | 1 | Register write strobe |
| spr_sel | input | 1 | 0 selects the watch address, 1 the control word |
| spr_wdata | input | 64 | Register write data |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_ea | input | 64 | Effective address of the access |
| acc_is_store | input | 1 | 1 for store, 0 for load |
| msr_pr | input | 1 | Machine is in problem state |
| msr_hv | input | 1 | Machine is in hypervisor state |
| msr_dr | input | 1 | Data relocation is on |
| irq_dsi | output | 1 | Data-storage interrupt request, one cycle per hit |
| fault_addr | output | 64 | Address to load into the fault-address register |
| fault_status | output | 64 | Status word with the watchpoint cause bit |

## Verification
A register write takes effect at the clock edge that samples it, so an access driven in the following cycle already sees the new value. An access is sampled at one rising edge, and all three results appear one register later, just after that same edge. Every check is therefore taken 1 ns after the edge that captured the access. The cycle that follows is sampled as well, to confirm that the outputs return to zero once the access is gone. Back-to-back hitting accesses are checked edge by edge, to show that each access produces its own single-cycle report.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
  localparam int XLEN = 64;

  // big-endian bit n maps to little-endian index XLEN-1-n
  localparam int CB_RD  = XLEN - 1 - 57;
  localparam int CB_WR  = XLEN - 1 - 58;
  localparam int CB_WT  = XLEN - 1 - 59;
  localparam int CB_WTI = XLEN - 1 - 60;
  localparam int CB_HV  = XLEN - 1 - 61;
  localparam int CB_SV  = XLEN - 1 - 62;
  localparam int CB_PR  = XLEN - 1 - 63;
  localparam int SB_WATCH = XLEN - 1 - 41;
  localparam logic [XLEN-1:0] STATUS_WATCH = XLEN'(1) << SB_WATCH;

  typedef struct packed {
    logic rd_en;
    logic wr_en;
    logic wt;
    logic wti;
    logic hv_en;
    logic sv_en;
    logic pr_en;
  } wctl_t;

  function automatic wctl_t decode_ctl(logic [XLEN-1:0] w);
    wctl_t c;
    c.rd_en = w[CB_RD];
    c.wr_en = w[CB_WR];
    c.wt    = w[CB_WT];
    c.wti   = w[CB_WTI];
    c.hv_en = w[CB_HV];
    c.sv_en = w[CB_SV];
    c.pr_en = w[CB_PR];
    return c;
  endfunction

  // privilege chain: problem, then hypervisor, then supervisor
  function automatic logic priv_ok(wctl_t c, logic pr, logic hv);
    if (pr && !c.pr_en)      return 1'b0;
    else if (hv && !c.hv_en) return 1'b0;
    else if (!c.sv_en)       return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic xlat_ok(wctl_t c, logic dr);
    return c.wti || (dr == c.wt);
  endfunction

  function automatic logic dir_ok(wctl_t c, logic is_store);
    return is_store ? c.wr_en : c.rd_en;
  endfunction
endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs
  import dwatch_pkg::*;
#(
  parameter int OFS_BITS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     sel,
  input  logic [XLEN-1:0]          wdata,
  output logic [XLEN-1:OFS_BITS]   watch_dw,
  output wctl_t                    ctl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      watch_dw <= '0;
      ctl      <= '0;
    end else if (we) begin
      if (!sel) watch_dw <= wdata[XLEN-1:OFS_BITS];
      else      ctl      <= decode_ctl(wdata);
    end
  end
endmodule

// File: rtl/dwatch_qual.sv
module dwatch_qual
  import dwatch_pkg::*;
#(
  parameter int OFS_BITS = 3
) (
  input  logic                   valid,
  input  logic [XLEN-1:0]        ea,
  input  logic                   is_store,
  input  logic                   pr,
  input  logic                   hv,
  input  logic                   dr,
  input  logic [XLEN-1:OFS_BITS] watch_dw,
  input  wctl_t                  ctl,
  output logic                   addr_pass,
  output logic                   priv_pass,
  output logic                   xlat_pass,
  output logic                   dir_pass,
  output logic                   hit
);
  always_comb begin
    addr_pass = (ea[XLEN-1:OFS_BITS] == watch_dw);
    priv_pass = priv_ok(ctl, pr, hv);
    xlat_pass = xlat_ok(ctl, dr);
    dir_pass  = dir_ok(ctl, is_store);
    hit       = valid && addr_pass && priv_pass && xlat_pass && dir_pass;
  end
endmodule

// File: rtl/dwatch_report.sv
module dwatch_report
  import dwatch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [XLEN-1:0] ea,
  output logic            irq,
  output logic [XLEN-1:0] fault_addr,
  output logic [XLEN-1:0] fault_status
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq          <= 1'b0;
      fault_addr   <= '0;
      fault_status <= '0;
    end else begin
      irq          <= hit;
      fault_addr   <= hit ? ea : '0;
      fault_status <= hit ? STATUS_WATCH : '0;
    end
  end

  p_hit_report_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (irq && fault_addr == $past(ea) && fault_status == STATUS_WATCH));

  p_quiet_after_miss_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!irq && fault_addr == '0 && fault_status == '0));

  p_status_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(fault_status) == 1 && fault_status[SB_WATCH]));
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter int OFS_BITS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spr_we,
  input  logic            spr_sel,
  input  logic [63:0]     spr_wdata,
  input  logic            acc_valid,
  input  logic [63:0]     acc_ea,
  input  logic            acc_is_store,
  input  logic            msr_pr,
  input  logic            msr_hv,
  input  logic            msr_dr,
  output logic            irq_dsi,
  output logic [63:0]     fault_addr,
  output logic [63:0]     fault_status
);
  logic [XLEN-1:OFS_BITS] watch_dw;
  wctl_t                  ctl;
  logic addr_pass, priv_pass, xlat_pass, dir_pass, wp_hit;

  dwatch_regs #(.OFS_BITS(OFS_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(spr_we), .sel(spr_sel), .wdata(spr_wdata),
    .watch_dw(watch_dw), .ctl(ctl)
  );

  dwatch_qual #(.OFS_BITS(OFS_BITS)) u_qual (
    .valid(acc_valid), .ea(acc_ea), .is_store(acc_is_store),
    .pr(msr_pr), .hv(msr_hv), .dr(msr_dr),
    .watch_dw(watch_dw), .ctl(ctl),
    .addr_pass(addr_pass), .priv_pass(priv_pass), .xlat_pass(xlat_pass),
    .dir_pass(dir_pass), .hit(wp_hit)
  );

  dwatch_report u_report (
    .clk(clk), .rst_n(rst_n), .hit(wp_hit), .ea(acc_ea),
    .irq(irq_dsi), .fault_addr(fault_addr), .fault_status(fault_status)
  );

  p_pr_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && msr_pr && !ctl.pr_en) |-> !wp_hit);

  p_hv_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && msr_hv && !ctl.hv_en) |-> !wp_hit);

  p_sv_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> ctl.sv_en);

  p_xlat_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !ctl.wti && (msr_dr != ctl.wt)) |-> !wp_hit);

  p_dir_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> (acc_is_store ? ctl.wr_en : ctl.rd_en));

  p_addr_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wp_hit |-> (acc_ea[XLEN-1:OFS_BITS] == watch_dw));

  p_idle_no_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !wp_hit);
endmodule

// File: tb/test_dwatch_unit.sv
module test_dwatch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spr_we = 1'b0, spr_sel = 1'b0;
  logic [63:0] spr_wdata = '0;
  logic        acc_valid = 1'b0, acc_is_store = 1'b0;
  logic [63:0] acc_ea = '0;
  logic        msr_pr = 1'b0, msr_hv = 1'b0, msr_dr = 1'b0;
  logic        irq_dsi;
  logic [63:0] fault_addr, fault_status;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // control bits, little-endian index = 63 - big-endian number
  localparam logic [63:0] K_PR  = 64'h1 << 0;   // bit 63
  localparam logic [63:0] K_SV  = 64'h1 << 1;   // bit 62
  localparam logic [63:0] K_HV  = 64'h1 << 2;   // bit 61
  localparam logic [63:0] K_WTI = 64'h1 << 3;   // bit 60
  localparam logic [63:0] K_WT  = 64'h1 << 4;   // bit 59
  localparam logic [63:0] K_WR  = 64'h1 << 5;   // bit 58
  localparam logic [63:0] K_RD  = 64'h1 << 6;   // bit 57
  localparam logic [63:0] ALL   = K_PR | K_SV | K_HV | K_WTI | K_RD | K_WR;
  localparam logic [63:0] ST_EXP = 64'h0000_0000_0040_0000;

  dwatch_unit i_dwatch_unit (
    .clk(clk), .rst_n(rst_n), .spr_we(spr_we), .spr_sel(spr_sel),
    .spr_wdata(spr_wdata), .acc_valid(acc_valid), .acc_ea(acc_ea),
    .acc_is_store(acc_is_store), .msr_pr(msr_pr), .msr_hv(msr_hv),
    .msr_dr(msr_dr), .irq_dsi(irq_dsi), .fault_addr(fault_addr),
    .fault_status(fault_status)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    @(negedge clk);
    spr_we = 1'b1; spr_sel = sel; spr_wdata = d;
    @(negedge clk);
    spr_we = 1'b0;
  endtask

  // one access, result checked just after the capturing edge, then idle check
  task automatic acc(input logic [63:0] ea, input logic st, input logic pr,
                     input logic hv, input logic dr, input bit exp_hit,
                     input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_ea = ea; acc_is_store = st;
    msr_pr = pr; msr_hv = hv; msr_dr = dr;
    @(posedge clk); #1;
    chk(irq_dsi == exp_hit, req, {63'b0, irq_dsi}, {63'b0, exp_hit});
    chk(fault_addr == (exp_hit ? ea : 64'h0), req, fault_addr, exp_hit ? ea : 64'h0);
    chk(fault_status == (exp_hit ? ST_EXP : 64'h0), req, fault_status,
        exp_hit ? ST_EXP : 64'h0);
    @(negedge clk);
    acc_valid = 1'b0;
    @(posedge clk); #1;
    chk(irq_dsi == 1'b0 && fault_addr == 64'h0, "R11 idle after access",
        fault_addr, 64'h0);
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    chk(irq_dsi == 0 && fault_addr == 0 && fault_status == 0, "R1 reset outputs",
        fault_status, 64'h0);
    acc(64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 cleared regs give no hit");
  endtask

  task automatic t_addr;
    wr(1'b0, 64'h0000_0000_0000_1000);
    wr(1'b1, ALL);
    acc(64'h1005, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R2 R3 R10 offset bits ignored");
    acc(64'h1007, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3 store at top of doubleword");
    acc(64'h1008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 next doubleword");
    acc(64'h8000_0000_0000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 high bit differs");
  endtask

  task automatic t_dir;
    wr(1'b1, K_PR | K_SV | K_HV | K_WTI | K_RD);
    acc(64'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 store disabled");
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 load enabled");
    wr(1'b1, K_PR | K_SV | K_HV | K_WTI | K_WR);
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 load disabled");
    acc(64'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 store enabled");
  endtask

  task automatic t_priv;
    wr(1'b1, ALL & ~K_PR);
    acc(64'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 problem state blocked");
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 supervisor still hits");
    wr(1'b1, ALL & ~K_HV);
    acc(64'h1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6 hypervisor blocked");
    acc(64'h1000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 problem+hv blocked");
    acc(64'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R6 problem without hv hits");
    wr(1'b1, ALL & ~K_SV);
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 supervisor blocked");
    acc(64'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 problem needs sv too");
    acc(64'h1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 hv needs sv too");
  endtask

  task automatic t_xlat;
    wr(1'b1, (ALL & ~K_WTI) | K_WT);
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8 wt=1 dr=1 hits");
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 wt=1 dr=0 blocked");
    wr(1'b1, ALL & ~K_WTI);
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 wt=0 dr=0 hits");
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 wt=0 dr=1 blocked");
    wr(1'b1, ALL | K_WT);
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 ignore dr=0");
    acc(64'h1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R9 ignore dr=1");
  endtask

  task automatic t_stream;
    wr(1'b1, ALL);
    @(negedge clk);
    acc_valid = 1'b1; acc_ea = 64'h1001; acc_is_store = 1'b0;
    msr_pr = 1'b0; msr_hv = 1'b0; msr_dr = 1'b0;
    @(posedge clk); #1;
    chk(irq_dsi && fault_addr == 64'h1001, "R11 first of pair", fault_addr, 64'h1001);
    @(negedge clk);
    acc_ea = 64'h1006;
    @(posedge clk); #1;
    chk(irq_dsi && fault_addr == 64'h1006, "R11 second of pair", fault_addr, 64'h1006);
    @(negedge clk);
    acc_ea = 64'h2000;
    @(posedge clk); #1;
    chk(!irq_dsi && fault_status == 0, "R11 miss after hits", fault_status, 64'h0);
    @(negedge clk);
    acc_valid = 1'b0; acc_ea = 64'h1000;
    @(posedge clk); #1;
    chk(!irq_dsi && fault_addr == 0, "R11 matching address without valid",
        fault_addr, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr();
    t_dir();
    t_priv();
    t_xlat();
    t_stream();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule